// File: doc/BRIEF.md
# Programmable periodic and one-shot event timer

This block is a down-counting event timer. It advances only when a one-cycle tick enable from outside arrives, normally once per microsecond. Software programs it through a small register bus. A single control word carries an arm bit, a repeat bit and a 29-bit count. A programmed count of n makes the timer expire on the (n+1)-th tick after it is armed.

On expiry the block sets a pending flag, which drives a level-high interrupt. In repeat mode the counter reloads from the control word and keeps firing. In single-shot mode it fires once and then disarms itself. Software acknowledges the interrupt by writing a dedicated bit in a second register. That register also reads back the live down-count and the pending flag.

Top module: `evt_timer`

## Requirements
- R1: After synchronous reset, irq is low and both registers read 0x00000000.
- R2: The control word at offset 0x0 uses bit 31 as the arm bit, bit 30 as the repeat bit and bits [28:0] as the count. It reads back with bit 29 as zero.
- R3: A control write with bit 31 set loads the down-counter from bits [28:0]; the maximum count is 0x1FFFFFFF. The status register at offset 0x4 shows the down-count in bits [28:0].
- R4: The down-count falls by one on each tick while armed. With count n, irq rises after the (n+1)-th tick and not before.
- R5: In repeat mode (bit 30 = 1), expiry reloads the count and the timer fires again every n+1 ticks.
- R6: In single-shot mode, expiry clears the arm bit, which reads back as 0. Later ticks do not fire again.
- R7: Writing 0 to the control word stops the timer: ticks neither change the down-count nor raise irq.
- R8: irq is level-high and stays high until acknowledged. The status register shows it as bit 30.
- R9: A write to offset 0x4 with bit 30 = 1 clears irq. A write there with bit 30 = 0 has no effect.
- R10: If an acknowledge and a new expiry fall in the same cycle, irq stays high.
- R11: A control write takes precedence over a tick arriving in the same cycle; that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | ADDR_W | Byte offset: 0x0 control, 0x4 status/acknowledge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not selected) |
| irq | output | 1 | Level-high interrupt |

## Verification
If the down-counter holds a wrong value, the status register shows it as soon as software reads it. irq then also rises on the wrong tick, early or late by the size of the error. A stale arm bit shows in the control readback one cycle after a single-shot expiry, and appears as a second interrupt on the next tick. A pending flag that loses a collision with an acknowledge drops irq in the very next cycle, even though the timer just expired.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ARM_BIT  = 31;
    localparam int unsigned REP_BIT  = 30;
    localparam int unsigned PEND_BIT = 30;
    localparam int unsigned ACK_BIT  = 30;
    localparam int unsigned CNT_W    = REP_BIT - 1;
    localparam int unsigned OFF_CTRL = 0;
    localparam int unsigned OFF_STAT = 4;

    typedef struct packed {
        logic             arm;
        logic             rep;
        logic [CNT_W-1:0] count;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ARM_BIT]     = c.arm;
        w[REP_BIT]     = c.rep;
        w[CNT_W-1:0]   = c.count;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(logic pend, logic [CNT_W-1:0] cnt);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PEND_BIT]    = pend;
        w[CNT_W-1:0]   = cnt;
        return w;
    endfunction

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              single_done,
    output ctrl_t             ctrl,
    output logic              ctrl_wr,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              ack
);

    logic  stat_wr;
    ctrl_t ctrl_d;
    logic  unused_bit29;

    assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign stat_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
    assign load     = ctrl_wr && bus_wdata[ARM_BIT];
    assign load_val = bus_wdata[CNT_W-1:0];
    assign ack      = stat_wr && bus_wdata[ACK_BIT];
    assign unused_bit29 = bus_wdata[CNT_W];

    always_comb begin
        ctrl_d = ctrl;
        if (ctrl_wr) begin
            ctrl_d.arm   = bus_wdata[ARM_BIT];
            ctrl_d.rep   = bus_wdata[REP_BIT];
            ctrl_d.count = bus_wdata[CNT_W-1:0];
        end else if (single_done) begin
            ctrl_d.arm   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= ctrl_d;
    end

    assert_single_disarm_R6: assert property (@(posedge clk) disable iff (rst)
        (single_done && !ctrl_wr) |=> !ctrl.arm);

    assert_stop_write_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata == '0) |=> (!ctrl.arm && ctrl.count == '0));

endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
    parameter int unsigned CNT_W = evt_timer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             armed,
    input  logic             repeat_mode,
    input  logic             hold,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    logic step;
    logic at_zero;

    assign step    = armed && tick && !hold;
    assign at_zero = (cnt == '0);
    assign expire  = step && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            if (at_zero) cnt <= repeat_mode ? reload_val : '0;
            else         cnt <= cnt - 1'b1;
        end
    end

    assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !at_zero && !load) |=> (cnt == $past(cnt) - 1'b1));

    assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));

    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (expire && repeat_mode) |=> (cnt == $past(reload_val)));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(cnt));

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ack,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst)         pend <= 1'b0;
        else if (expire) pend <= 1'b1;
        else if (ack)    pend <= 1'b0;
    end

    assert_expire_sets_R8: assert property (@(posedge clk) disable iff (rst)
        expire |=> pend);

    assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && !expire) |=> !pend);

    assert_collision_R10: assert property (@(posedge clk) disable iff (rst)
        (ack && expire) |=> pend);

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    ctrl_t            ctrl;
    logic             ctrl_wr;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             ack;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             pend;
    logic             single_done;

    assign single_done = expire && !ctrl.rep;

    evt_timer_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .single_done (single_done),
        .ctrl        (ctrl),
        .ctrl_wr     (ctrl_wr),
        .load        (load),
        .load_val    (load_val),
        .ack         (ack)
    );

    evt_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .armed       (ctrl.arm),
        .repeat_mode (ctrl.rep),
        .hold        (ctrl_wr),
        .load        (load),
        .load_val    (load_val),
        .reload_val  (ctrl.count),
        .cnt         (cnt),
        .expire      (expire)
    );

    evt_timer_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .ack    (ack),
        .pend   (pend)
    );

    assign irq = pend;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_CTRL))      bus_rdata = pack_ctrl(ctrl);
            else if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = pack_stat(pend, cnt);
        end
    end

    assert_no_fire_disarmed_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.arm && !pend && !expire) |=> !irq);

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    evt_timer u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h4, v); chk("R1 stat", v, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h8000_0003);
        rd(4'h4, v); chk("R3 load", v, 32'h0000_0003);
        ticks(3);
        rd(4'h4, v); chk("R4 count", v, 32'h0);
        chk("R4 early", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R4 fire", {31'b0, irq}, 32'h1);
        rd(4'h0, v); chk("R6 disarm", v, 32'h0000_0003);
        rd(4'h4, v); chk("R8 pend bit", v, 32'h4000_0000);
        ticks(2);
        chk("R8 level", {31'b0, irq}, 32'h1);
        wr(4'h4, 32'h4000_0000);
        chk("R9 ack", {31'b0, irq}, 32'h0);
        ticks(5);
        chk("R6 once", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_repeat();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'hC000_0002);
        ticks(3);
        chk("R5 first", {31'b0, irq}, 32'h1);
        rd(4'h4, v); chk("R5 reload", v, 32'h4000_0002);
        wr(4'h4, 32'h4000_0000);
        ticks(2);
        chk("R5 gap", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R5 second", {31'b0, irq}, 32'h1);
        rd(4'h0, v); chk("R5 armed", v, 32'hC000_0002);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h8000_0005);
        ticks(2);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R7 ctrl", v, 32'h0);
        ticks(10);
        rd(4'h4, v); chk("R7 frozen", v, 32'h0000_0003);
        chk("R7 no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ack_zero();
        do_reset();
        wr(4'h0, 32'h8000_0000);
        ticks(1);
        chk("R4 n0", {31'b0, irq}, 32'h1);
        wr(4'h4, 32'hBFFF_FFFF);
        chk("R9 no effect", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_collision();
        do_reset();
        wr(4'h0, 32'hC000_0000);
        ticks(1);
        chk("R10 pre", {31'b0, irq}, 32'h1);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4;
        bus_wdata = 32'h4000_0000; tick = 1'b1;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
        chk("R10 collide", {31'b0, irq}, 32'h1);
        wr(4'h4, 32'h4000_0000);
        chk("R10 later ack", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_max_and_priority();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'hBFFF_FFFF);
        rd(4'h0, v); chk("R2 bit29", v, 32'h9FFF_FFFF);
        ticks(1);
        rd(4'h4, v); chk("R3 max", v, 32'h1FFF_FFFE);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0;
        bus_wdata = 32'h8000_0004; tick = 1'b1;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
        rd(4'h4, v); chk("R11 write wins", v, 32'h0000_0004);
    endtask

    initial begin
        t_reset();
        t_single();
        t_repeat();
        t_stop();
        t_ack_zero();
        t_collision();
        t_max_and_priority();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule